// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block is a store-and-forward stage on the transmit side of an Ethernet interface. It takes an outgoing frame byte by byte from an input stream, keeps it in a local buffer, and, when the frame's control words ask for it, computes a 16-bit ones-complement checksum over the tail of the frame. It then writes that checksum back into the buffered frame at a chosen byte position and sends the result on an output stream. The input and output streams carry one byte per beat with valid, ready and an end-of-frame marker.

Each frame comes with three 32-bit control words, taken with its first byte. They carry an insertion enable, the start offset of the sum, the offset of the write-back and a 16-bit seed. A transmit configuration word, sampled with the frame's final byte, decides whether the frame is sent at all and whether the length limit applies. Every frame that is sent adds its length to a running byte counter and sets a sticky completion flag.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset, s_ready is 1, m_valid is 0, tx_byte_cnt is 0 and tx_done is 0.
- R2: No byte of a frame appears on the output before its final input byte is accepted. While a frame is being sent, s_ready is 0. Output bytes come out in input order, and m_last is 1 on the final one only.
- R3: Bit 0 of ctl0 enables insertion. With it clear, the frame leaves unchanged. ctl0, ctl1 and ctl2 are sampled only in the cycle the first byte of a frame is accepted, and later changes during the frame have no effect.
- R4: The checksum is the ones-complement of the folded sum of ctl2[15:0] and the big-endian 16-bit words that start at byte offset ctl1[31:16] and run to the end of the frame. An odd last byte counts as a high byte with a zero low byte. Carries out of bit 15 are added back in until none remain. A start offset at or past the frame end leaves only the seed.
- R5: The high checksum byte replaces the frame byte at offset ctl1[15:0], and the low byte replaces the one at that offset plus 1. An offset that falls past the frame end changes nothing.
- R6: When tx_cfg bit 28 is 0 at the final input byte, the frame is dropped. Nothing is output, tx_byte_cnt and tx_done are unchanged, and s_ready stays 1.
- R7: When tx_cfg bits 30 and 27 are both 0, a frame of 1519 to 1522 bytes is dropped as in R6. Setting either bit lets such frames through. Lengths of 1518 or less, or 1523 or more, are never dropped by this rule.
- R8: When the final output byte is taken, tx_byte_cnt grows by the frame length and tx_done becomes 1. tx_done returns to 0 the cycle after clr_done is 1, unless a frame completes in that same cycle.
- R9: Input bytes beyond BUF_BYTES (default 4096) are discarded. They are neither stored nor summed, and the frame leaves with exactly BUF_BYTES bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_cfg | input | 32 | Transmit configuration: bit 28 enable, bit 30 jumbo, bit 27 VLAN |
| ctl0 | input | 32 | Per-frame control word 0, bit 0 enables insertion |
| ctl1 | input | 32 | Per-frame control word 1: start offset [31:16], write offset [15:0] |
| ctl2 | input | 32 | Per-frame control word 2: seed in [15:0] |
| s_data | input | 8 | Input frame byte |
| s_valid | input | 1 | Input byte valid |
| s_last | input | 1 | Input byte is the last of the frame |
| s_ready | output | 1 | Block accepts an input byte |
| m_data | output | 8 | Output frame byte |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Output byte is the last of the frame |
| m_ready | input | 1 | Downstream accepts the output byte |
| tx_byte_cnt | output | CNT_W | Total bytes of sent frames |
| tx_done | output | 1 | Sticky frame-sent flag |
| clr_done | input | 1 | Clears tx_done |

## Verification
The hardest case to reach from the ports is the interaction between the sum's word alignment and the write-back. This covers an odd-length tail, a start offset past the end, and a write offset whose low byte falls just off the frame. It also covers a frame long enough to be truncated, where the sum must stop at the buffer edge. Directed frames place offsets at exactly these edges, including a 4100-byte frame and lengths on both sides of the 1518/1522 limits. Random frames then vary offsets, seeds, idle gaps and output stalls, and the control words are scrambled after each first byte to show they were latched.

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
  parameter int BUF_BYTES = 4096,
  parameter int CNT_W     = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      tx_cfg,
  input  logic [31:0]      ctl0,
  input  logic [31:0]      ctl1,
  input  logic [31:0]      ctl2,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic [7:0]       m_data,
  output logic             m_valid,
  output logic             m_last,
  input  logic             m_ready,
  output logic [CNT_W-1:0] tx_byte_cnt,
  output logic             tx_done,
  input  logic             clr_done
);
  localparam int AW        = $clog2(BUF_BYTES);
  localparam int CW        = $clog2(BUF_BYTES + 1);
  localparam int EN_BIT    = 28;
  localparam int VLAN_BIT  = 27;
  localparam int JUMBO_BIT = 30;
  localparam int STD_MAX   = 1518;
  localparam int TAG_MAX   = 1522;

  logic [7:0]    mem [BUF_BYTES];
  logic          sending, phase, ins_en;
  logic [CW-1:0] cnt, rd_idx;
  logic [15:0]   start_q, woff_q;
  logic [31:0]   acc;

  logic unused_bits;
  assign unused_bits = ^{ctl0[31:1], ctl2[31:16], tx_cfg[31], tx_cfg[29], tx_cfg[26:0]};

  assign s_ready = !sending;
  assign m_valid = sending;

  wire          take      = s_valid && s_ready;
  wire          first     = (cnt == '0);
  wire [15:0]   cur_start = first ? ctl1[31:16] : start_q;
  wire          cur_phase = first ? 1'b0 : phase;
  wire          room      = 32'(cnt) < BUF_BYTES;
  wire          in_sum    = room && (32'(cnt) >= 32'(cur_start));
  wire [31:0]   acc_base  = first ? {16'b0, ctl2[15:0]} : acc;
  wire [31:0]   addend    = cur_phase ? {24'b0, s_data} : {16'b0, s_data, 8'b0};
  wire [CW-1:0] cnt_nxt   = room ? cnt + 1'b1 : cnt;
  wire          tag_len   = (32'(cnt_nxt) > STD_MAX) && (32'(cnt_nxt) <= TAG_MAX);
  wire          drop      = !tx_cfg[EN_BIT] || (!tx_cfg[JUMBO_BIT] && !tx_cfg[VLAN_BIT] && tag_len);

  wire [16:0] fold1 = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
  wire [15:0] fold2 = fold1[15:0] + {15'b0, fold1[16]};
  wire [15:0] csum  = ~fold2;

  wire [31:0] rd32 = 32'(rd_idx);
  assign m_last = (rd32 + 1) == 32'(cnt);
  assign m_data = (ins_en && rd32 == 32'(woff_q))      ? csum[15:8] :
                  (ins_en && rd32 == 32'(woff_q) + 1)  ? csum[7:0]  :
                  mem[rd_idx[AW-1:0]];

  always_ff @(posedge clk)
    if (!sending && take && room) mem[cnt[AW-1:0]] <= s_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending     <= 1'b0;
      phase       <= 1'b0;
      ins_en      <= 1'b0;
      cnt         <= '0;
      rd_idx      <= '0;
      start_q     <= '0;
      woff_q      <= '0;
      acc         <= '0;
      tx_byte_cnt <= '0;
      tx_done     <= 1'b0;
    end else begin
      if (!sending && take) begin
        if (first) begin
          start_q <= ctl1[31:16];
          woff_q  <= ctl1[15:0];
          ins_en  <= ctl0[0];
        end
        if (in_sum) begin
          acc   <= acc_base + addend;
          phase <= !cur_phase;
        end else if (first) begin
          acc   <= acc_base;
          phase <= 1'b0;
        end
        if (s_last && drop) cnt <= '0;
        else                cnt <= cnt_nxt;
        if (s_last && !drop) sending <= 1'b1;
      end
      if (sending && m_ready) begin
        if (m_last) begin
          sending     <= 1'b0;
          cnt         <= '0;
          rd_idx      <= '0;
          tx_byte_cnt <= tx_byte_cnt + CNT_W'(cnt);
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
      if (sending && m_ready && m_last) tx_done <= 1'b1;
      else if (clr_done)                tx_done <= 1'b0;
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (32'(cnt) <= BUF_BYTES) && (cnt != '0)); // R9
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> tx_byte_cnt == $past(tx_byte_cnt) + CNT_W'($past(cnt))); // R8
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> tx_done); // R8
  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take && s_last && !tx_cfg[EN_BIT] |=> !m_valid && $stable(tx_byte_cnt)); // R6
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid && !(take && s_last) |=> !m_valid); // R2
endmodule

// File: tb/tx_csum_inserter_tb_top.sv
module tx_csum_inserter_tb_top;
  localparam int BUF = 4096;
  localparam int MAXF = 4200;
  localparam logic [31:0] CFG_EN = 32'h1000_0000, CFG_VLAN = 32'h0800_0000, CFG_JUMBO = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] tx_cfg = 0, ctl0 = 0, ctl1 = 0, ctl2 = 0;
  logic [7:0] s_data = 0, m_data;
  logic s_valid = 0, s_last = 0, s_ready, m_valid, m_last, m_ready = 0, tx_done, clr_done = 0;
  logic [47:0] tx_byte_cnt;

  tx_csum_inserter dut_i (.clk(clk), .rst_n(rst_n), .tx_cfg(tx_cfg), .ctl0(ctl0), .ctl1(ctl1),
    .ctl2(ctl2), .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
    .tx_byte_cnt(tx_byte_cnt), .tx_done(tx_done), .clr_done(clr_done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  longint exp_cnt = 0;
  logic [7:0] fr [MAXF];
  logic [7:0] ex [MAXF];
  logic [7:0] got [MAXF];

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_csum(int len, int st, logic [15:0] seed);
    logic [31:0] s = {16'b0, seed};
    for (int i = st; i < len; i += 2)
      s += {16'b0, fr[i], (i + 1 < len) ? fr[i+1] : 8'h00};
    while (s[31:16] != 0) s = {16'b0, s[15:0]} + {16'b0, s[31:16]};
    return ~s[15:0];
  endfunction

  task automatic run_frame(int len, bit en, int st, int wo, logic [31:0] cfg, string req);
    logic [15:0] seed = 16'($urandom);
    logic [15:0] c;
    int keep = (len > BUF) ? BUF : len;
    bit dropped = !cfg[28] || (!cfg[30] && !cfg[27] && len > 1518 && len <= 1522);
    int early = 0, busy = 0, n = 0, bad = -1;
    bit fin = 0;
    longint cnt0 = tx_byte_cnt;
    bit done0 = tx_done;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < keep; i++) ex[i] = fr[i];
    c = ref_csum(keep, st, seed);
    if (en) begin
      if (wo < keep) ex[wo] = c[15:8];
      if (wo + 1 < keep) ex[wo+1] = c[7:0];
    end
    tx_cfg = cfg;
    ctl0 = {$urandom, en} >> 0;
    ctl0[0] = en;
    ctl1 = {16'(st), 16'(wo)};
    ctl2 = {16'($urandom), seed};
    for (int i = 0; i < len; i++) begin
      if ($urandom % 5 == 0) begin @(negedge clk); s_valid = 0; end
      @(negedge clk);
      if (i == 1) begin ctl0 = $urandom; ctl1 = $urandom; ctl2 = $urandom; end
      if (m_valid) early++;
      s_valid = 1; s_data = fr[i]; s_last = (i == len - 1);
    end
    @(negedge clk); s_valid = 0; s_last = 0;
    chk(early == 0, "R2", {req, " output before frame end"}, early, 0);
    if (dropped) begin
      repeat (4) begin @(negedge clk); if (m_valid || !s_ready) busy++; end
      chk(busy == 0, req, "dropped frame produced output", busy, 0);
      chk(tx_byte_cnt == cnt0, req, "count after drop", tx_byte_cnt, cnt0);
      chk(tx_done == done0, req, "done after drop", tx_done, done0);
      return;
    end
    while (!fin) begin
      if (m_valid && s_ready) busy++;
      m_ready = ($urandom % 4) != 0;
      if (m_valid && m_ready) begin
        got[n] = m_data;
        if (m_last) fin = 1;
        else if (n < MAXF - 1) n++;
      end
      @(negedge clk);
    end
    m_ready = 0;
    n++;
    for (int i = 0; i < keep && i < n; i++) if (bad < 0 && got[i] != ex[i]) bad = i;
    chk(busy == 0, "R2", {req, " input ready while sending"}, busy, 0);
    chk(n == keep, (len > BUF) ? "R9" : "R2", {req, " output length"}, n, keep);
    chk(bad < 0, req, $sformatf("byte %0d", bad), (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : ex[bad]);
    exp_cnt += keep;
    chk(tx_byte_cnt == exp_cnt, "R8", {req, " byte counter"}, tx_byte_cnt, exp_cnt);
    chk(tx_done == 1, "R8", {req, " done set"}, tx_done, 1);
    clr_done = 1; @(negedge clk); clr_done = 0;
    chk(tx_done == 0, "R8", "done cleared", tx_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready && !m_valid && tx_byte_cnt == 0 && !tx_done, "R1", "reset state",
        {s_ready, m_valid, tx_done}, 3'b100);
    run_frame(60, 0, 14, 20, CFG_EN, "R3 plain");
    run_frame(64, 1, 14, 50, CFG_EN, "R4 even");
    run_frame(61, 1, 20, 30, CFG_EN, "R4 odd tail");
    run_frame(40, 1, 44, 10, CFG_EN, "R4 start past end");
    run_frame(33, 1, 2, 32, CFG_EN, "R5 low byte off end");
    run_frame(1, 1, 0, 0, CFG_EN, "R5 single byte");
    run_frame(50, 1, 0, 10, 32'h0, "R6 disabled");
    run_frame(1520, 1, 14, 40, CFG_EN, "R7 drop 1520");
    run_frame(1522, 0, 0, 0, CFG_EN, "R7 drop 1522");
    run_frame(1520, 1, 14, 40, CFG_EN | CFG_VLAN, "R7 vlan 1520");
    run_frame(1519, 1, 15, 16, CFG_EN | CFG_JUMBO, "R7 jumbo 1519");
    run_frame(1518, 1, 14, 24, CFG_EN, "R7 1518");
    run_frame(1523, 1, 3, 5, CFG_EN, "R7 1523");
    run_frame(4100, 1, 4001, 4094, CFG_EN, "R9 truncate");
    for (int k = 0; k < 24; k++) begin
      int len = 1 + $urandom % 200;
      run_frame(len, 1'($urandom), $urandom % (len + 4), $urandom % (len + 3), CFG_EN, "R4 R5 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule